// File: doc/BRIEF.md
# Two-Bank Frequency Memory Controller

This block runs the key sequence that saves and recalls tuning words for a signal source with two outputs, F1 and F2. It receives decoded key events, one per cycle with a valid flag, and the current tuning words of both outputs. It holds eighteen stored settings in internal registers, split into a lower bank and an upper bank of nine slots each.

A store or recall follows a fixed sequence. The memory key opens the sequence. Left or Right then picks the bank, and a digit picks the slot. Finally, `.` stores the word of the currently selected output, or `0` recalls the slot. A recall sends the stored word back out with a one-cycle load strobe, aimed at the output the word was taken from. A mode code and a status code drive a display.

The FSM has four states:

| State | Mode code | Waits for |
|---|---|---|
| NORMAL | 0 | The memory key |
| BANK | 1 | Left or Right |
| SLOT | 2 | A digit |
| ACTION | 3 | `0` or `.` |

The transitions are:

| Transition | From | To | Taken when |
|---|---|---|---|
| enter | NORMAL | BANK | Memory key |
| pick-bank | BANK | SLOT | Left or Right |
| pick-slot | SLOT | ACTION | Digit 1..9 |
| recall | ACTION | NORMAL | `0` |
| store | ACTION | NORMAL | `.` |
| abort | any memory state | NORMAL | Cancel or any key not accepted in that state |

Top module: `fmem_ctrl`

## Requirements
- R1: After reset the mode code is 0 (NORMAL), the status code is 0 (IDLE), `load_stb` is low, and every slot is empty.
- R2: Key code 11 (MEM) pressed in NORMAL moves to mode 1 (BANK) and sets the status to IDLE. Any other key in NORMAL leaves the mode, the status and the table unchanged and produces no strobe.
- R3: In BANK, key code 12 (LEFT) selects the lower bank and key code 13 (RIGHT) selects the upper bank. Either key moves to mode 2 (SLOT).
- R4: In SLOT, a digit key with code 1..9 moves to mode 3 (ACTION) and selects slot digit-1 of the chosen bank.
- R5: In ACTION, key code 10 (`.`) stores a word and returns to NORMAL with status 2 (WRITE). If `sel_out` is 0 the stored word is `f1_word`; if it is 1 the stored word is `f2_word`. The slot is marked valid and `sel_out` is recorded as its source.
- R6: In ACTION, key code 0 on a valid slot returns to NORMAL with status 1 (READ). In the cycle after that key, `load_stb` is high for exactly one cycle, `load_word` carries the stored word, and `load_dst` carries the recorded source.
- R7: In ACTION, key code 0 on an empty slot returns to NORMAL with status 3 (EMPTY) and produces no strobe.
- R8: In any memory state, key code 14 (CANCEL), or any key that state does not accept, returns to NORMAL with status 4 (ABORT). The table is left unchanged.
- R9: `load_stb` is never high in two consecutive cycles and is high only right after an accepted recall.
- R10: The lower and upper banks are independent: the same digit in each bank addresses a different slot. A store overwrites only its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | A key event is present this cycle |
| key_code | input | 4 | Key: 0-9 digits, 10 `.`, 11 MEM, 12 LEFT, 13 RIGHT, 14 CANCEL |
| sel_out | input | 1 | Output currently selected for tuning: 0 = F1, 1 = F2 |
| f1_word | input | 48 | Current tuning word of F1 |
| f2_word | input | 48 | Current tuning word of F2 |
| load_stb | output | 1 | One-cycle recall strobe |
| load_word | output | 48 | Recalled tuning word, valid with `load_stb` |
| load_dst | output | 1 | Output to load: 0 = F1, 1 = F2 |
| mode_code | output | 2 | 0 NORMAL, 1 BANK, 2 SLOT, 3 ACTION |
| status_code | output | 3 | 0 IDLE, 1 READ, 2 WRITE, 3 EMPTY, 4 ABORT |

## Verification
The bench builds the block with its default parameters: 48-bit words and nine slots per bank. These values make the two highest slots, lower 9 and upper 9, reachable through ordinary digit keys. Full-width words with set top bits show that no bit is lost between store and recall. Aborts and recalls of empty slots are mixed between stores, so any write that leaks outside its own slot or bank shows up in a later recall.

// File: rtl/fmem_pkg.sv
package fmem_pkg;

    localparam int KEY_W = 4;

    localparam logic [KEY_W-1:0] K_DOT    = 4'd10;
    localparam logic [KEY_W-1:0] K_MEM    = 4'd11;
    localparam logic [KEY_W-1:0] K_LEFT   = 4'd12;
    localparam logic [KEY_W-1:0] K_RIGHT  = 4'd13;
    localparam logic [KEY_W-1:0] K_CANCEL = 4'd14;

    typedef enum logic [1:0] {
        M_NORMAL = 2'd0,
        M_BANK   = 2'd1,
        M_SLOT   = 2'd2,
        M_ACTION = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_EMPTY = 3'd3,
        ST_ABORT = 3'd4
    } stat_e;

    function automatic logic is_slot_digit(input logic [KEY_W-1:0] k, input int per_bank);
        return (k >= 4'd1) && (int'(k) <= per_bank);
    endfunction

endpackage

// File: rtl/fmem_seq.sv
module fmem_seq
    import fmem_pkg::*;
#(
    parameter int PER_BANK = 9,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_code,
    input  logic             slot_full,
    output mode_e            mode,
    output stat_e            status,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en,
    output logic             rd_en
);

    mode_e            mode_nx;
    stat_e            status_nx;
    logic             bank_q, bank_nx;
    logic [IDX_W-1:0] idx_nx;

    always_comb begin
        mode_nx   = mode;
        status_nx = status;
        bank_nx   = bank_q;
        idx_nx    = idx;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        if (key_valid) begin
            unique case (mode)
                M_NORMAL: begin
                    if (key_code == K_MEM) begin
                        mode_nx   = M_BANK;
                        status_nx = ST_IDLE;
                    end
                end
                M_BANK: begin
                    if (key_code == K_LEFT || key_code == K_RIGHT) begin
                        mode_nx = M_SLOT;
                        bank_nx = (key_code == K_RIGHT);
                    end else begin
                        mode_nx   = M_NORMAL;
                        status_nx = ST_ABORT;
                    end
                end
                M_SLOT: begin
                    if (is_slot_digit(key_code, PER_BANK)) begin
                        mode_nx = M_ACTION;
                        idx_nx  = IDX_W'(key_code - 4'd1)
                                + (bank_q ? IDX_W'(PER_BANK) : '0);
                    end else begin
                        mode_nx   = M_NORMAL;
                        status_nx = ST_ABORT;
                    end
                end
                M_ACTION: begin
                    mode_nx = M_NORMAL;
                    if (key_code == 4'd0) begin
                        rd_en     = 1'b1;
                        status_nx = slot_full ? ST_READ : ST_EMPTY;
                    end else if (key_code == K_DOT) begin
                        wr_en     = 1'b1;
                        status_nx = ST_WRITE;
                    end else begin
                        status_nx = ST_ABORT;
                    end
                end
                default: mode_nx = M_NORMAL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= M_NORMAL;
            bank_q <= 1'b0;
            idx    <= '0;
        end else begin
            mode   <= mode_nx;
            bank_q <= bank_nx;
            idx    <= idx_nx;
        end
    end

    // display status register
    always_ff @(posedge clk) begin
        if (!rst_n) status <= ST_IDLE;
        else        status <= status_nx;
    end

endmodule

// File: rtl/fmem_table.sv
module fmem_table #(
    parameter int WORD_W = 48,
    parameter int NSLOT  = 18,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_src,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_src,
    output logic              rd_full
);

    logic [WORD_W-1:0] words [NSLOT];
    logic [NSLOT-1:0]  full;
    logic [NSLOT-1:0]  srcs;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [WORD_W-1:0] w_q;
        logic              v_q;
        logic              s_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                s_q <= 1'b0;
                w_q <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                v_q <= 1'b1;
                s_q <= wr_src;
                w_q <= wr_word;
            end
        end
        assign words[g] = w_q;
        assign full[g]  = v_q;
        assign srcs[g]  = s_q;
    end

    always_comb begin
        rd_word = '0;
        rd_src  = 1'b0;
        rd_full = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_word = words[i];
                rd_src  = srcs[i];
                rd_full = full[i];
            end
        end
    end

endmodule

// File: rtl/fmem_ctrl.sv
module fmem_ctrl
    import fmem_pkg::*;
#(
    parameter int WORD_W   = 48,
    parameter int PER_BANK = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [3:0]        key_code,
    input  logic              sel_out,
    input  logic [WORD_W-1:0] f1_word,
    input  logic [WORD_W-1:0] f2_word,
    output logic              load_stb,
    output logic [WORD_W-1:0] load_word,
    output logic              load_dst,
    output logic [1:0]        mode_code,
    output logic [2:0]        status_code
);

    localparam int NSLOT = 2 * PER_BANK;
    localparam int IDX_W = $clog2(NSLOT);

    mode_e             mode;
    stat_e             status;
    logic [IDX_W-1:0]  idx;
    logic              wr_en, rd_en, rd_full, rd_src;
    logic [WORD_W-1:0] rd_word;

    fmem_seq #(.PER_BANK(PER_BANK), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .slot_full(rd_full), .mode(mode), .status(status), .idx(idx),
        .wr_en(wr_en), .rd_en(rd_en)
    );

    fmem_table #(.WORD_W(WORD_W), .NSLOT(NSLOT), .IDX_W(IDX_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx),
        .wr_word(sel_out ? f2_word : f1_word), .wr_src(sel_out),
        .rd_word(rd_word), .rd_src(rd_src), .rd_full(rd_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_stb  <= 1'b0;
            load_word <= '0;
            load_dst  <= 1'b0;
        end else begin
            load_stb <= rd_en && rd_full;
            if (rd_en && rd_full) begin
                load_word <= rd_word;
                load_dst  <= rd_src;
            end
        end
    end

    assign mode_code   = mode;
    assign status_code = status;

endmodule

// File: rtl/fmem_ctrl_chk.sv
module fmem_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       key_valid,
    input logic [3:0] key_code,
    input logic       load_stb,
    input logic [1:0] mode_code,
    input logic [2:0] status_code
);

    p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    p_stb_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_stb) |-> $past(key_valid && key_code == 4'd0 && mode_code == 2'd3));

    p_stb_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> status_code == 3'd1);

    p_mem_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && mode_code == 2'd0 && key_code == 4'd11) |=> mode_code == 2'd1);

    p_action_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && mode_code == 2'd3) |=> mode_code == 2'd0);

    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_code == 4'd14 && mode_code != 2'd0)
        |=> (mode_code == 2'd0 && status_code == 3'd4));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid) |=> $stable(mode_code) && $stable(status_code));

    always_comb begin
        if (rst_n) begin
            p_status_range_r1: assert (status_code <= 3'd4);
        end
    end

endmodule

bind fmem_ctrl fmem_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .load_stb(load_stb), .mode_code(mode_code), .status_code(status_code)
);

// File: tb/tb_fmem_ctrl.sv
module tb_fmem_ctrl;

    localparam int W = 48;
    localparam int PB = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_valid = 1'b0;
    logic [3:0]   key_code = 4'd0;
    logic         sel_out = 1'b0;
    logic [W-1:0] f1_word = '0;
    logic [W-1:0] f2_word = '0;
    logic         load_stb;
    logic [W-1:0] load_word;
    logic         load_dst;
    logic [1:0]   mode_code;
    logic [2:0]   status_code;

    int n_chk = 0;
    int n_fail = 0;
    string req_tag = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    fmem_ctrl #(.WORD_W(W), .PER_BANK(PB)) dut (.*);

    // behavioural reference model
    int           m_mode, m_status, m_bank, m_slot;
    bit           m_stb, m_dst;
    logic [W-1:0] m_word;
    logic [W-1:0] mem_w [2*PB];
    bit           mem_v [2*PB];
    bit           mem_s [2*PB];

    always @(posedge clk) begin
        m_stb = 0;
        if (!rst_n) begin
            m_mode = 0; m_status = 0; m_bank = 0; m_slot = 0;
            for (int i = 0; i < 2*PB; i++) mem_v[i] = 0;
        end else if (key_valid) begin
            int k;
            k = int'(key_code);
            case (m_mode)
                0: if (k == 11) begin m_mode = 1; m_status = 0; end
                1: if (k == 12 || k == 13) begin m_mode = 2; m_bank = (k == 13); end
                   else begin m_mode = 0; m_status = 4; end
                2: if (k >= 1 && k <= PB) begin m_mode = 3; m_slot = m_bank*PB + k - 1; end
                   else begin m_mode = 0; m_status = 4; end
                default: begin
                    m_mode = 0;
                    if (k == 0) begin
                        if (mem_v[m_slot]) begin
                            m_status = 1; m_stb = 1;
                            m_word = mem_w[m_slot]; m_dst = mem_s[m_slot];
                        end else m_status = 3;
                    end else if (k == 10) begin
                        m_status = 2; mem_v[m_slot] = 1; mem_s[m_slot] = sel_out;
                        mem_w[m_slot] = sel_out ? f2_word : f1_word;
                    end else m_status = 4;
                end
            endcase
        end
    end

    task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(req_tag, "mode", mode_code, m_mode);
            check(req_tag, "status", status_code, m_status);
            check("R9", "load_stb", load_stb, m_stb);
            if (m_stb) begin
                check(req_tag, "load_word", load_word, m_word);
                check(req_tag, "load_dst", load_dst, m_dst);
            end
        end
    end

    task automatic press(int k);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = 4'(k);
        @(negedge clk);
        key_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic seq3(int bank_key, int digit, int act);
        press(11); press(bank_key); press(digit); press(act);
    endtask

    // recall and check the strobe explicitly in the cycle after the key
    task automatic recall(string req, int bank_key, int digit, bit exp_hit,
                          logic [W-1:0] exp_w, bit exp_d);
        press(11); press(bank_key); press(digit);
        @(negedge clk);
        key_valid = 1'b1; key_code = 4'd0;
        @(negedge clk);
        key_valid = 1'b0;
        check(req, "recall strobe", load_stb, exp_hit);
        if (exp_hit) begin
            check(req, "recall word", load_word, exp_w);
            check(req, "recall dst", load_dst, exp_d);
        end
        check(req, "recall status", status_code, exp_hit ? 1 : 3);
        @(negedge clk);
        check("R9", "strobe single", load_stb, 0);
        @(negedge clk);
    endtask

    initial begin
        #500us;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        req_tag = "R1";
        check("R1", "reset mode", mode_code, 0);
        check("R1", "reset status", status_code, 0);
        check("R1", "reset strobe", load_stb, 0);

        // R2: non-MEM keys in normal are ignored
        req_tag = "R2";
        press(0); press(5); press(10); press(12);
        check("R2", "ignored mode", mode_code, 0);
        check("R2", "ignored status", status_code, 0);
        recall("R1", 12, 1, 0, '0, 0);

        // R5/R3/R4: store F1 in lower 1, F2 in upper 1
        req_tag = "R5";
        f1_word = 48'hA5A5_1234_5678; f2_word = 48'h8000_0000_0001; sel_out = 0;
        seq3(12, 1, 10);
        check("R5", "write status", status_code, 2);
        sel_out = 1;
        seq3(13, 1, 10);
        req_tag = "R6";
        recall("R6", 12, 1, 1, 48'hA5A5_1234_5678, 0);
        recall("R10", 13, 1, 1, 48'h8000_0000_0001, 1);

        // R7: empty slot
        req_tag = "R7";
        recall("R7", 12, 2, 0, '0, 0);

        // boundary slots 9 of each bank
        req_tag = "R4";
        f1_word = 48'hFFFF_FFFF_FFFF; f2_word = 48'h0000_0000_0009; sel_out = 0;
        seq3(12, 9, 10);
        sel_out = 1;
        seq3(13, 9, 10);
        recall("R4", 12, 9, 1, 48'hFFFF_FFFF_FFFF, 0);
        recall("R3", 13, 9, 1, 48'h0000_0000_0009, 1);

        // R8: cancel and invalid keys at each step, table unchanged
        req_tag = "R8";
        f1_word = 48'h1111_1111_1111; sel_out = 0;
        press(11); press(14);
        check("R8", "cancel in bank", status_code, 4);
        press(11); press(12); press(14);
        press(11); press(12); press(1); press(14);
        press(11); press(3);
        press(11); press(13); press(0);
        press(11); press(12); press(1); press(11);
        press(11); press(12); press(1); press(12);
        check("R8", "abort mode", mode_code, 0);
        check("R8", "abort status", status_code, 4);
        recall("R8", 12, 1, 1, 48'hA5A5_1234_5678, 0);

        // R10: overwrite lower 1 leaves upper 1
        req_tag = "R10";
        f2_word = 48'h2222_3333_4444; sel_out = 1;
        seq3(12, 1, 10);
        recall("R10", 12, 1, 1, 48'h2222_3333_4444, 1);
        recall("R10", 13, 1, 1, 48'h8000_0000_0001, 1);

        // R2: MEM clears status to IDLE
        req_tag = "R2";
        press(11);
        check("R2", "mem entry mode", mode_code, 1);
        check("R2", "mem entry status", status_code, 0);
        press(14);

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule